// File: doc/BRIEF.md
# Zero-Page Bit-Test Branch Unit

This unit executes a conditional branch that tests a single bit of a byte held in zero page. The fetch stage hands it the opcode, the two operand bytes (a zero-page address and a signed 8-bit displacement) and the fall-through address, meaning the address of the byte that follows the three-byte instruction. The unit issues one read of the zero-page byte and picks the bit whose number is encoded in the opcode. It decides whether to branch on that bit being clear or set. It then reports the next program counter and a cycle count.

The sequence always lasts five cycles, whether or not the branch is taken. No status flags are touched. The states are named as follows. `ST_IDLE` waits for `start` and is cycle 1 of an instruction. `ST_ADDR` (cycle 2) holds the latched operands. `ST_READ` (cycle 3) drives the single memory read. `ST_TEST` (cycle 4) receives the byte, evaluates the bit and forms the target. `ST_DONE` (cycle 5) presents the result with `done` high. The transitions are:
- `ST_IDLE` to `ST_ADDR` on `start`.
- `ST_ADDR` to `ST_READ` to `ST_TEST` to `ST_DONE` unconditionally.
- `ST_DONE` back to `ST_IDLE`.

Top module: `bitbranch_unit`

## Requirements
- R1: After reset, `busy`, `done` and `rd_en` are 0 and `cycles` is 0.
- R2: For each accepted instruction, `rd_en` is high for exactly one cycle, in cycle 3 (the second cycle after `start` was sampled). `rd_addr` is then `{8'h00, zp_addr}`. The memory returns `rd_data` in the following cycle.
- R3: The bit tested is `rd_data[opcode[6:4]]`. Opcode bits 3:0 have no effect on the result.
- R4: Opcode bit 7 selects the sense: 1 branches if the tested bit is 1, and 0 branches if it is 0. `taken` reports the decision.
- R5: When taken, `next_pc` equals `fall_pc` plus `disp` sign-extended to 16 bits, modulo 65536.
- R6: When not taken, `next_pc` equals `fall_pc`.
- R7: `done` is high for exactly one cycle, in cycle 5 (the fourth cycle after `start` was sampled), taken or not. At that time `cycles` reads 5. `taken` and `next_pc` are valid while `done` is high.
- R8: A `start` pulse while `busy` is high is ignored. Neither the result nor the timing of the instruction in flight changes.
- R9: `busy` is high in cycles 2 to 5 of an instruction and low in the cycle after `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Instruction present from fetch (accepted only when idle) |
| opcode | input | 8 | Opcode: bits 6:4 bit number, bit 7 sense |
| zp_addr | input | 8 | Zero-page address operand |
| disp | input | 8 | Signed branch displacement operand |
| fall_pc | input | 16 | Address of the byte after the instruction |
| rd_en | output | 1 | Memory read request |
| rd_addr | output | 16 | Memory read address (zero page) |
| rd_data | input | 8 | Read data, valid the cycle after `rd_en` |
| busy | output | 1 | Instruction in progress (cycles 2 to 5) |
| done | output | 1 | Result valid (cycle 5) |
| taken | output | 1 | Branch decision |
| next_pc | output | 16 | Next program counter |
| cycles | output | 3 | Cycle count of the instruction, 5 at `done` |

## Verification
The sweep covers every bit number with both senses. Each combination is tried against four memory bytes:
- all zeros and all ones, which separate the two senses;
- a one-hot byte and its complement at the selected bit, which prove that the chosen bit, and not a neighbour, drives the decision.

The displacements 0x00, 0x7F, 0x80 and 0xFF, combined with fall-through addresses near 0x0000 and near 0xFFFF, separate correct sign extension and 16-bit wraparound from zero extension or a carry into a wider sum. A start pulse injected mid-sequence, carrying a contrary opcode, shows whether the latched instruction is disturbed.

// File: rtl/bbr_pkg.sv
package bbr_pkg;

    localparam int OPC_W       = 8;
    localparam int OPC_IDX_LSB = 4;
    localparam int OPC_SENSE   = 7;
    localparam int SEQ_CYCLES  = 5;
    localparam int CYC_W       = 3;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_ADDR = 3'd1,
        ST_READ = 3'd2,
        ST_TEST = 3'd3,
        ST_DONE = 3'd4
    } bbr_state_t;

endpackage

// File: rtl/bbr_seq.sv
module bbr_seq
    import bbr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    output logic             accept_o,
    output logic             read_o,
    output logic             capture_o,
    output logic             done_o,
    output logic             busy_o,
    output logic [CYC_W-1:0] cyc_o
);

    bbr_state_t       state_q, state_d;
    logic [CYC_W-1:0] cyc_q;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start_i) state_d = ST_ADDR;
            ST_ADDR: state_d = ST_READ;
            ST_READ: state_d = ST_TEST;
            ST_TEST: state_d = ST_DONE;
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // state register and cycle counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cyc_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_d == ST_IDLE)
                cyc_q <= '0;
            else if (state_q == ST_IDLE)
                cyc_q <= CYC_W'(2);
            else
                cyc_q <= cyc_q + 1'b1;
        end
    end

    // outputs
    always_comb begin
        accept_o  = 1'b0;
        read_o    = 1'b0;
        capture_o = 1'b0;
        done_o    = 1'b0;
        busy_o    = 1'b1;
        unique case (state_q)
            ST_IDLE: begin
                busy_o   = 1'b0;
                accept_o = start_i;
            end
            ST_ADDR: ;
            ST_READ: read_o    = 1'b1;
            ST_TEST: capture_o = 1'b1;
            ST_DONE: done_o    = 1'b1;
            default: busy_o    = 1'b0;
        endcase
    end

    assign cyc_o = cyc_q;

    assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    assert_done_count_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (cyc_q == CYC_W'(SEQ_CYCLES)));
    assert_read_once_R2: assert property (@(posedge clk) disable iff (!rst_n)
        read_o |=> !read_o);
    assert_busy_after_accept_R9: assert property (@(posedge clk) disable iff (!rst_n)
        accept_o |=> (busy_o && cyc_q == CYC_W'(2)));

endmodule

// File: rtl/bbr_bit_select.sv
module bbr_bit_select #(
    parameter int DATA_W = 8,
    localparam int IDX_W = $clog2(DATA_W)
) (
    input  logic [DATA_W-1:0] data_i,
    input  logic [IDX_W-1:0]  idx_i,
    input  logic              sense_i,
    output logic              taken_o
);

    logic [DATA_W-1:0] hit;

    for (genvar i = 0; i < DATA_W; i++) begin : g_tap
        assign hit[i] = (idx_i == IDX_W'(i)) && data_i[i];
    end

    // sense 1: branch on a set bit; sense 0: branch on a clear bit
    assign taken_o = sense_i ? (|hit) : !(|hit);

endmodule

// File: rtl/bbr_target_add.sv
module bbr_target_add #(
    parameter int ADDR_W = 16,
    parameter int DISP_W = 8
) (
    input  logic [ADDR_W-1:0] base_i,
    input  logic [DISP_W-1:0] disp_i,
    input  logic              taken_i,
    output logic [ADDR_W-1:0] next_o
);

    logic [ADDR_W-1:0] disp_ext;
    logic [ADDR_W-1:0] sum;

    assign disp_ext = {{(ADDR_W-DISP_W){disp_i[DISP_W-1]}}, disp_i};
    assign sum      = base_i + disp_ext;   // wraps modulo 2**ADDR_W
    assign next_o   = taken_i ? sum : base_i;

endmodule

// File: rtl/bitbranch_unit.sv
module bitbranch_unit
    import bbr_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [7:0]        opcode,
    input  logic [DATA_W-1:0] zp_addr,
    input  logic [DATA_W-1:0] disp,
    input  logic [ADDR_W-1:0] fall_pc,
    output logic              rd_en,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic [DATA_W-1:0] rd_data,
    output logic              busy,
    output logic              done,
    output logic              taken,
    output logic [ADDR_W-1:0] next_pc,
    output logic [2:0]        cycles
);

    localparam int IDX_W  = $clog2(DATA_W);
    localparam int PAGE_W = ADDR_W - DATA_W;

    logic              accept, read, capture;
    logic [OPC_W-1:0]  op_q;
    logic [DATA_W-1:0] zp_q, disp_q;
    logic [ADDR_W-1:0] pc_q;
    logic              taken_d, taken_q;
    logic [ADDR_W-1:0] next_d, next_q;

    bbr_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start),
        .accept_o  (accept),
        .read_o    (read),
        .capture_o (capture),
        .done_o    (done),
        .busy_o    (busy),
        .cyc_o     (cycles)
    );

    // operand latch, loaded only when the sequencer accepts
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q   <= '0;
            zp_q   <= '0;
            disp_q <= '0;
            pc_q   <= '0;
        end else if (accept) begin
            op_q   <= opcode;
            zp_q   <= zp_addr;
            disp_q <= disp;
            pc_q   <= fall_pc;
        end
    end

    assign rd_en   = read;
    assign rd_addr = {{PAGE_W{1'b0}}, zp_q};

    bbr_bit_select #(.DATA_W(DATA_W)) u_bit (
        .data_i  (rd_data),
        .idx_i   (op_q[OPC_IDX_LSB +: IDX_W]),
        .sense_i (op_q[OPC_SENSE]),
        .taken_o (taken_d)
    );

    bbr_target_add #(.ADDR_W(ADDR_W), .DISP_W(DATA_W)) u_add (
        .base_i  (pc_q),
        .disp_i  (disp_q),
        .taken_i (taken_d),
        .next_o  (next_d)
    );

    // result register, loaded in cycle 4 and presented in cycle 5
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            taken_q <= 1'b0;
            next_q  <= '0;
        end else if (capture) begin
            taken_q <= taken_d;
            next_q  <= next_d;
        end
    end

    assign taken   = taken_q;
    assign next_pc = next_q;

    assert_opcode_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> ($stable(op_q) && $stable(pc_q) && $stable(disp_q)));
    assert_read_before_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(rd_en, 2));
    assert_fallthrough_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !taken) |-> (next_pc == pc_q));
    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!rd_en && !done));

endmodule

// File: tb/tb_bitbranch_unit.sv
`timescale 1ns/1ps
module tb_bitbranch_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [7:0]  opcode = '0;
    logic [7:0]  zp_addr = '0;
    logic [7:0]  disp = '0;
    logic [15:0] fall_pc = '0;
    logic        rd_en;
    logic [15:0] rd_addr;
    logic [7:0]  rd_data = '0;
    logic        busy, done, taken;
    logic [15:0] next_pc;
    logic [2:0]  cycles;

    int checks = 0;
    int failures = 0;
    int reads = 0;
    logic [15:0] seen_addr = '0;
    logic [7:0]  mem_val = '0;

    always #2 clk = ~clk;

    bitbranch_unit dut (
        .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode),
        .zp_addr(zp_addr), .disp(disp), .fall_pc(fall_pc),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
        .busy(busy), .done(done), .taken(taken), .next_pc(next_pc),
        .cycles(cycles)
    );

    // synchronous zero-page memory model
    always @(posedge clk) begin
        if (rd_en) begin
            rd_data   <= mem_val;
            seen_addr <= rd_addr;
            reads     <= reads + 1;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic run_one(input int bitn, input bit sense, input logic [7:0] mval,
                           input logic [7:0] d, input logic [15:0] pc, input bit inject);
        logic        exp_taken;
        logic [15:0] exp_pc;
        int          reads0;
        exp_taken = sense ? mval[bitn] : !mval[bitn];
        exp_pc    = exp_taken ? 16'(pc + {{8{d[7]}}, d}) : pc;
        @(negedge clk);
        reads0  = reads;
        mem_val = mval;
        opcode  = {sense, 3'(bitn), 4'hF};
        zp_addr = 8'(8'h35 + bitn);
        disp    = d;
        fall_pc = pc;
        start   = 1'b1;
        @(negedge clk);                 // cycle 2
        start   = 1'b0;
        opcode  = ~opcode;
        disp    = ~d;
        fall_pc = ~pc;
        chk("R9 busy cycle2", busy, 1'b1);
        @(negedge clk);                 // cycle 3
        chk("R2 rd_en cycle3", rd_en, 1'b1);
        chk("R2 rd_addr", rd_addr, {8'h00, 8'(8'h35 + bitn)});
        if (inject) begin
            start  = 1'b1;              // R8: must be ignored
            opcode = {~sense, 3'(bitn), 4'h0};
        end
        @(negedge clk);                 // cycle 4
        start = 1'b0;
        chk("R7 no early done", done, 1'b0);
        @(negedge clk);                 // cycle 5
        chk("R7 done cycle5", done, 1'b1);
        chk("R7 cycles", cycles, 3'd5);
        chk("R2 single read", reads - reads0, 1);
        if (exp_taken) begin
            chk("R4 taken sense", taken, exp_taken);
            chk("R5 target", next_pc, exp_pc);
        end else begin
            chk("R3 bit decision", taken, exp_taken);
            chk("R6 fallthrough", next_pc, exp_pc);
        end
        if (inject) chk("R8 inject no effect", {taken, next_pc}, {exp_taken, exp_pc});
        @(negedge clk);                 // cycle 6
        chk("R9 busy clear", busy, 1'b0);
        chk("R7 done single", done, 1'b0);
    endtask

    initial begin
        logic [7:0] pats[4];
        logic [7:0] disps[4];
        logic [15:0] pcs[2];
        disps = '{8'h00, 8'h7F, 8'h80, 8'hFF};
        pcs   = '{16'h0003, 16'hFFF0};
        repeat (3) @(negedge clk);
        chk("R1 busy reset", busy, 1'b0);
        chk("R1 done reset", done, 1'b0);
        chk("R1 rd_en reset", rd_en, 1'b0);
        chk("R1 cycles reset", cycles, 3'd0);
        rst_n = 1'b1;
        for (int b = 0; b < 8; b++) begin
            pats = '{8'h00, 8'hFF, 8'(1 << b), ~8'(1 << b)};
            for (int s = 0; s < 2; s++)
                for (int m = 0; m < 4; m++)
                    for (int k = 0; k < 4; k++)
                        for (int p = 0; p < 2; p++)
                            run_one(b, s[0], pats[m], disps[k], pcs[p], (k == 1 && p == 1));
        end
        // R5 wrap below zero, R8 injection on a not-taken case
        run_one(0, 1'b1, 8'h01, 8'h80, 16'h0010, 1'b1);
        run_one(7, 1'b0, 8'h80, 8'h10, 16'hFFFF, 1'b1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule